// File: doc/BRIEF.md
# Dual-Plane Flash Status Bit Generator

This block forms the status portion of a read word for a NOR flash array model that has two planes and runs embedded program and erase operations. The array model tells it which operation is running, which plane that operation occupies, and, when an erase is on hold, which plane and sector hold the suspended erase. For every read it decides one of two things. Either the array model returns the true stored data, or this block supplies the polling bit (data line 7), the main toggle bit (line 6) and the suspend toggle bit (line 2).

Software tells a finished operation from a running one by watching line 7 settle to the true data value, or by reading the same plane twice and seeing line 6 stop changing. Line 2 is what separates the sector whose erase is suspended from its neighbours. Reads of the plane that is not busy always get true data, so code can keep running from that plane. A pull-low enable for a shared open-drain ready/busy wire stays asserted for the whole internal cycle.

Operation codes on `op_kind`: 0 idle, 1 program, 2 erase, 3 erase suspended, 4 program while an erase is suspended. A read counts as completed at the clock edge where `rd_strobe` is sampled low, provided it was sampled high at the edge before. Both toggle flip-flops change only at such an edge, and the new value shows on the outputs after that edge.

Top module: `flst_status_gen`

## Requirements
- R1: With op_kind 1, a read whose plane equals op_plane gives pass_data 0, st7 equal to the inverse of loaded_b7, and st2 equal to 1.
- R2: With op_kind 2, a read whose plane equals op_plane gives pass_data 0 and st7 equal to 0.
- R3: With op_kind 1 or 2, st6 shows the main toggle flip-flop for reads of op_plane. That flip-flop inverts once for each completed read of op_plane, and a completed read of the other plane leaves it unchanged.
- R4: With op_kind 2, st2 shows the suspend toggle flip-flop for reads of op_plane, and that flip-flop inverts once for each such completed read.
- R5: With op_kind 1 or 2, a read of the plane other than op_plane gives pass_data 1, and st7, st6 and st2 are all 0.
- R6: With op_kind 3, a read that matches both susp_plane and susp_sector gives pass_data 0, st7 1, st6 1 and st2 from the suspend toggle flip-flop, and that flip-flop inverts once per completed read. Any other read gives pass_data 1.
- R7: With op_kind 4, a read that matches the suspended sector behaves as in R6. Any other read of op_plane gives st7 equal to the inverse of loaded_b7, st6 from the main toggle and st2 from the suspend toggle, and both flip-flops invert once per completed read. Reads of the remaining plane give pass_data 1.
- R8: busy_pull is 1 while op_kind is 1, 2 or 4, and 0 while op_kind is 0 or 3.
- R9: While rst is 1, pass_data is 1, busy_pull is 0 and the status bits are 0. Both toggle flip-flops are 0 after reset, so the first status read after reset shows st6 = 0.
- R10: With op_kind 0, every read gives pass_data 1, and completed reads leave both toggle flip-flops unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_kind | input | 3 | Running operation code (0 to 4) |
| op_plane | input | PLANE_W | Plane of the running program or erase |
| susp_plane | input | PLANE_W | Plane holding the suspended erase |
| susp_sector | input | SECT_W | Sector holding the suspended erase |
| rd_plane | input | PLANE_W | Plane of the read address |
| rd_sector | input | SECT_W | Sector of the read address |
| loaded_b7 | input | 1 | Bit 7 of the last data word loaded for programming |
| rd_strobe | input | 1 | Read strobe; its high-to-low sample completes a read |
| st7 | output | 1 | Status value for data line 7 |
| st6 | output | 1 | Status value for data line 6 |
| st2 | output | 1 | Status value for data line 2 |
| pass_data | output | 1 | 1 when true array data must be returned |
| busy_pull | output | 1 | Pull-low enable for the open-drain ready/busy wire |

## Verification
The properties assume that `op_kind` only carries the codes 0 to 4. They also assume that a program running under a suspended erase never targets the suspended sector, and that every input changes only between clock edges. The toggle property further assumes that the operation and the read address stay fixed for the cycle after a completed read. The stimulus meets all of these by changing inputs only at the falling clock edge and using only legal codes. Each strobe pulse is one high cycle followed by one low cycle with a fixed address, and the suspended sector and program plane are chosen so that they never coincide illegally.

// File: rtl/flst_pkg.sv
package flst_pkg;

    typedef enum logic [2:0] {
        OP_IDLE      = 3'd0,
        OP_PROG      = 3'd1,
        OP_ERASE     = 3'd2,
        OP_SUSP      = 3'd3,
        OP_SUSP_PROG = 3'd4
    } op_e;

    localparam int NUM_TGL = 2;
    localparam int TGL_MAIN = 0;
    localparam int TGL_SUSP = 1;

    typedef struct packed {
        logic                pass;
        logic                b7;
        logic                b6;
        logic                b2;
        logic [NUM_TGL-1:0]  adv;
    } stat_sel_t;

    function automatic logic op_holds_busy(op_e op);
        return (op == OP_PROG) || (op == OP_ERASE) || (op == OP_SUSP_PROG);
    endfunction

endpackage

// File: rtl/flst_decode.sv
module flst_decode
    import flst_pkg::*;
#(
    parameter int PLANE_W = 1,
    parameter int SECT_W  = 5
) (
    input  op_e                 op,
    input  logic [PLANE_W-1:0]  op_plane,
    input  logic [PLANE_W-1:0]  susp_plane,
    input  logic [SECT_W-1:0]   susp_sector,
    input  logic [PLANE_W-1:0]  rd_plane,
    input  logic [SECT_W-1:0]   rd_sector,
    input  logic                loaded_b7,
    input  logic [NUM_TGL-1:0]  tgl,
    output stat_sel_t           sel
);

    logic plane_hit;
    logic sect_hit;

    assign plane_hit = (rd_plane == op_plane);
    assign sect_hit  = (rd_plane == susp_plane) && (rd_sector == susp_sector);

    always_comb begin
        sel      = '0;
        sel.pass = 1'b1;
        case (op)
            OP_PROG: begin
                if (plane_hit) begin
                    sel.pass          = 1'b0;
                    sel.b7            = ~loaded_b7;
                    sel.b6            = tgl[TGL_MAIN];
                    sel.b2            = 1'b1;
                    sel.adv[TGL_MAIN] = 1'b1;
                end
            end
            OP_ERASE: begin
                if (plane_hit) begin
                    sel.pass = 1'b0;
                    sel.b7   = 1'b0;
                    sel.b6   = tgl[TGL_MAIN];
                    sel.b2   = tgl[TGL_SUSP];
                    sel.adv  = '1;
                end
            end
            OP_SUSP: begin
                if (sect_hit) begin
                    sel.pass          = 1'b0;
                    sel.b7            = 1'b1;
                    sel.b6            = 1'b1;
                    sel.b2            = tgl[TGL_SUSP];
                    sel.adv[TGL_SUSP] = 1'b1;
                end
            end
            OP_SUSP_PROG: begin
                if (sect_hit) begin
                    sel.pass          = 1'b0;
                    sel.b7            = 1'b1;
                    sel.b6            = 1'b1;
                    sel.b2            = tgl[TGL_SUSP];
                    sel.adv[TGL_SUSP] = 1'b1;
                end else if (plane_hit) begin
                    sel.pass = 1'b0;
                    sel.b7   = ~loaded_b7;
                    sel.b6   = tgl[TGL_MAIN];
                    sel.b2   = tgl[TGL_SUSP];
                    sel.adv  = '1;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/flst_toggle.sv
module flst_toggle #(
    parameter int N = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          done,
    input  logic [N-1:0]  adv,
    output logic [N-1:0]  q
);

    for (genvar i = 0; i < N; i++) begin : g_tgl
        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= 1'b0;
            end else if (done && adv[i]) begin
                q[i] <= ~q[i];
            end
        end
    end

endmodule

// File: rtl/flst_status_gen.sv
module flst_status_gen
    import flst_pkg::*;
#(
    parameter int PLANE_W = 1,
    parameter int SECT_W  = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          op_kind,
    input  logic [PLANE_W-1:0]  op_plane,
    input  logic [PLANE_W-1:0]  susp_plane,
    input  logic [SECT_W-1:0]   susp_sector,
    input  logic [PLANE_W-1:0]  rd_plane,
    input  logic [SECT_W-1:0]   rd_sector,
    input  logic                loaded_b7,
    input  logic                rd_strobe,
    output logic                st7,
    output logic                st6,
    output logic                st2,
    output logic                pass_data,
    output logic                busy_pull
);

    op_e                op;
    stat_sel_t          sel;
    logic [NUM_TGL-1:0] tgl;
    logic               strobe_q;
    logic               rd_done;

    assign op = op_e'(op_kind);

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= rd_strobe;
        end
    end

    assign rd_done = strobe_q && !rd_strobe;

    flst_decode #(
        .PLANE_W(PLANE_W),
        .SECT_W (SECT_W)
    ) u_decode (
        .op         (op),
        .op_plane   (op_plane),
        .susp_plane (susp_plane),
        .susp_sector(susp_sector),
        .rd_plane   (rd_plane),
        .rd_sector  (rd_sector),
        .loaded_b7  (loaded_b7),
        .tgl        (tgl),
        .sel        (sel)
    );

    flst_toggle #(
        .N(NUM_TGL)
    ) u_toggle (
        .clk (clk),
        .rst (rst),
        .done(rd_done),
        .adv (sel.adv),
        .q   (tgl)
    );

    always_comb begin
        if (rst) begin
            pass_data = 1'b1;
            st7       = 1'b0;
            st6       = 1'b0;
            st2       = 1'b0;
            busy_pull = 1'b0;
        end else begin
            pass_data = sel.pass;
            st7       = sel.b7;
            st6       = sel.b6;
            st2       = sel.b2;
            busy_pull = op_holds_busy(op);
        end
    end

endmodule

// File: rtl/flst_checker.sv
module flst_checker #(
    parameter int PLANE_W = 1,
    parameter int SECT_W  = 5
) (
    input logic                clk,
    input logic                rst,
    input logic [2:0]          op_kind,
    input logic [PLANE_W-1:0]  op_plane,
    input logic [PLANE_W-1:0]  susp_plane,
    input logic [SECT_W-1:0]   susp_sector,
    input logic [PLANE_W-1:0]  rd_plane,
    input logic [SECT_W-1:0]   rd_sector,
    input logic                loaded_b7,
    input logic                rd_strobe,
    input logic                st7,
    input logic                st6,
    input logic                st2,
    input logic                pass_data,
    input logic                busy_pull
);

    logic prev_strobe;
    logic same_plane;
    logic on_susp;
    logic main_used;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_strobe <= 1'b0;
        end else begin
            prev_strobe <= rd_strobe;
        end
    end

    assign same_plane = (rd_plane == op_plane);
    assign on_susp    = (rd_plane == susp_plane) && (rd_sector == susp_sector);
    assign main_used  = same_plane && ((op_kind == 3'd1) || (op_kind == 3'd2) ||
                        ((op_kind == 3'd4) && !on_susp));

    a_r1_prog_poll: assert property (@(posedge clk) disable iff (rst)
        (op_kind == 3'd1 && same_plane) |-> (!pass_data && st7 == !loaded_b7 && st2));

    a_r2_erase_zero: assert property (@(posedge clk) disable iff (rst)
        (op_kind == 3'd2 && same_plane) |-> (!pass_data && !st7));

    a_r3_main_toggles: assert property (@(posedge clk) disable iff (rst)
        (prev_strobe && !rd_strobe && main_used) |=>
        (!($stable(op_kind) && $stable(op_plane) && $stable(rd_plane) &&
           $stable(rd_sector) && $stable(susp_plane) && $stable(susp_sector))
         || (st6 != $past(st6))));

    a_r5_idle_plane: assert property (@(posedge clk) disable iff (rst)
        ((op_kind == 3'd1 || op_kind == 3'd2) && !same_plane) |->
        (pass_data && !st7 && !st6 && !st2));

    a_r6_susp_sector: assert property (@(posedge clk) disable iff (rst)
        ((op_kind == 3'd3 || op_kind == 3'd4) && on_susp) |-> (!pass_data && st7 && st6));

    a_r8_busy_wire: assert property (@(posedge clk) disable iff (rst)
        busy_pull == (op_kind == 3'd1 || op_kind == 3'd2 || op_kind == 3'd4));

    a_r9_reset_pass: assert property (@(posedge clk)
        rst |-> (pass_data && !busy_pull));

    a_r10_idle_pass: assert property (@(posedge clk) disable iff (rst)
        (op_kind == 3'd0) |-> pass_data);

endmodule

bind flst_status_gen flst_checker #(
    .PLANE_W(PLANE_W),
    .SECT_W (SECT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_kind    (op_kind),
    .op_plane   (op_plane),
    .susp_plane (susp_plane),
    .susp_sector(susp_sector),
    .rd_plane   (rd_plane),
    .rd_sector  (rd_sector),
    .loaded_b7  (loaded_b7),
    .rd_strobe  (rd_strobe),
    .st7        (st7),
    .st6        (st6),
    .st2        (st2),
    .pass_data  (pass_data),
    .busy_pull  (busy_pull)
);

// File: tb/flst_status_gen_bench.sv
module flst_status_gen_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] op_kind;
    logic [0:0] op_plane, susp_plane, rd_plane;
    logic [4:0] susp_sector, rd_sector;
    logic       loaded_b7, rd_strobe;
    logic       st7, st6, st2, pass_data, busy_pull;

    int checks = 0;
    int fails  = 0;
    int m_main = 0;
    int m_susp = 0;
    int m_prev = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flst_status_gen u_flst_status_gen (
        .clk(clk), .rst(rst), .op_kind(op_kind), .op_plane(op_plane),
        .susp_plane(susp_plane), .susp_sector(susp_sector),
        .rd_plane(rd_plane), .rd_sector(rd_sector), .loaded_b7(loaded_b7),
        .rd_strobe(rd_strobe), .st7(st7), .st6(st6), .st2(st2),
        .pass_data(pass_data), .busy_pull(busy_pull)
    );

    task automatic expect_now(output logic ep, output logic e7, output logic e6,
                              output logic e2, output bit um, output bit us,
                              output string tag);
        bit onp, ons;
        ep = 1; e7 = 0; e6 = 0; e2 = 0; um = 0; us = 0; tag = "R10";
        onp = (rd_plane == op_plane);
        ons = (rd_plane == susp_plane) && (rd_sector == susp_sector);
        if (rst) begin
            tag = "R9";
        end else if (op_kind == 1) begin
            tag = onp ? "R1" : "R5";
            if (onp) begin ep = 0; e7 = !loaded_b7; e6 = m_main[0]; e2 = 1; um = 1; end
        end else if (op_kind == 2) begin
            tag = onp ? "R2" : "R5";
            if (onp) begin ep = 0; e6 = m_main[0]; e2 = m_susp[0]; um = 1; us = 1; end
        end else if (op_kind == 3 || (op_kind == 4 && ons)) begin
            tag = (op_kind == 3) ? "R6" : "R7";
            if (ons) begin ep = 0; e7 = 1; e6 = 1; e2 = m_susp[0]; us = 1; end
        end else if (op_kind == 4) begin
            tag = "R7";
            if (onp) begin
                ep = 0; e7 = !loaded_b7; e6 = m_main[0]; e2 = m_susp[0]; um = 1; us = 1;
            end
        end
    endtask

    task automatic cmp(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cyc();
        logic ep, e7, e6, e2, eb;
        bit um, us;
        string tag;
        int n_main, n_susp;
        #1;
        expect_now(ep, e7, e6, e2, um, us, tag);
        eb = !rst && (op_kind == 1 || op_kind == 2 || op_kind == 4);
        cmp(tag, "pass_data", pass_data, ep);
        cmp(tag, "st7", st7, e7);
        cmp((tag == "R1" || tag == "R2") ? "R3" : tag, "st6", st6, e6);
        cmp((tag == "R2") ? "R4" : tag, "st2", st2, e2);
        cmp(rst ? "R9" : "R8", "busy_pull", busy_pull, eb);
        n_main = m_main; n_susp = m_susp;
        if (rst) begin
            n_main = 0; n_susp = 0;
        end else if (m_prev == 1 && !rd_strobe) begin
            if (um) n_main = 1 - m_main;
            if (us) n_susp = 1 - m_susp;
        end
        @(posedge clk);
        m_main = n_main; m_susp = n_susp;
        m_prev = rst ? 0 : int'(rd_strobe);
        @(negedge clk);
    endtask

    task automatic rd(logic [0:0] p, logic [4:0] s);
        rd_plane = p; rd_sector = s;
        rd_strobe = 1; cyc();
        rd_strobe = 0; cyc();
    endtask

    task automatic run_all();
        rst = 1; op_kind = 0; op_plane = 0; susp_plane = 0; susp_sector = 0;
        rd_plane = 0; rd_sector = 0; loaded_b7 = 0; rd_strobe = 0;
        // R9: reset forces pass-through and release of the busy wire
        cyc(); cyc();
        rst = 0;
        // R10: idle reads pass through and do not advance toggles
        rd(0, 1); rd(1, 2);
        // R1 and R3: program in plane 0, bit 7 complemented, bit 6 alternating
        op_kind = 1; op_plane = 0; loaded_b7 = 1;
        rd(0, 2); rd(0, 2); rd(0, 2);
        loaded_b7 = 0;
        rd(0, 7);
        // R5 and R3: other plane passes and leaves the toggle alone
        rd(1, 9); rd(1, 9); rd(0, 7);
        // R2 and R4: erase in plane 1
        op_kind = 2; op_plane = 1;
        rd(1, 3); rd(1, 3); rd(1, 3);
        rd(0, 3);
        // R6: suspended sector 3 of plane 1
        op_kind = 3; susp_plane = 1; susp_sector = 3;
        rd(1, 3); rd(1, 3); rd(1, 4); rd(0, 3); rd(1, 3);
        // R7: program in plane 0 while erase suspended in plane 1
        op_kind = 4; op_plane = 0; loaded_b7 = 1;
        rd(0, 5); rd(0, 5); rd(1, 3); rd(1, 6); rd(0, 3);
        // R7: program in the same plane as the suspended sector
        op_plane = 1; loaded_b7 = 0;
        rd(1, 8); rd(1, 3); rd(1, 8); rd(0, 8);
        // R10: operation finished, data is true everywhere
        op_kind = 0;
        rd(0, 5); rd(1, 3); rd(1, 8);
        // R9: reset in the middle of an erase clears the toggles
        op_kind = 2; op_plane = 0;
        rd(0, 1);
        rst = 1; cyc(); rst = 0;
        rd(0, 1); rd(0, 1);
        op_kind = 0; cyc();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule